// File: doc/BRIEF.md
# Per-Port Millisecond Input Debouncer

This block cleans up the eight input lines of one general-purpose port before they feed the input register and the interrupt detection logic. A single 8-bit threshold, given in milliseconds, is shared by every line of the port. Each line has its own filter-enable bit. Lines with the bit cleared are passed through unchanged. A line with the bit set only takes on a new value once its raw input has held that value for the programmed number of millisecond ticks.

A free-running prescaler produces the millisecond tick from the core clock. Its division ratio is a parameter. The enable bits are updated by a masked write. The upper half of the write word selects which bits change, and the lower half gives their new values. The raw inputs are assumed to be already synchronised to `clk`.

Top module: `dbn_port_filter`

## Requirements
- R1: A prescaler counts core clocks from reset and issues a one-cycle millisecond tick every CLKS_PER_MS clocks. The first tick comes on the CLKS_PER_MS-th rising edge after reset is released.
- R2: One threshold `dbc_count` is shared by all lines. Each line keeps its own tick counter, so lines that start disagreeing at different times switch at different times.
- R3: When `en_wr` is high at a rising edge, enable bit i takes `en_wdata[i]` if mask bit `en_wdata[PINS+i]` is 1, and keeps its value otherwise. Without `en_wr`, the enables do not change. `en_state` shows the enables.
- R4: A line whose enable bit is 0 drives `filt_out[i]` equal to `raw_in[i]` in the same cycle.
- R5: A line that is enabled (with a nonzero threshold) changes its output only on the rising edge of a tick. It does so on the tick at which its raw input has differed from its output for `dbc_count` consecutive ticks.
- R6: If the raw input returns to the output value before the threshold is reached, the line's counter clears and the output does not change.
- R7: A threshold of 0 acts as bypass for every line, even one that is enabled.
- R8: Synchronous active-low reset clears all enables, all held filter values and all counters.
- R9: The maximum threshold of 255 is honoured. After 254 ticks of disagreement the output is unchanged, and after the 255th tick it switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_in | input | PINS | Synchronised raw line levels |
| dbc_count | input | 8 | Shared threshold in milliseconds (0 = bypass) |
| en_wr | input | 1 | Masked enable write strobe |
| en_wdata | input | 2*PINS | Upper half is the mask, lower half the values |
| en_state | output | PINS | Current per-line enable bits |
| filt_out | output | PINS | Filtered line levels |

## Verification
The stimulus covers three kinds of raw input: a steady change that must switch after exactly the threshold, a pulse shorter than the threshold that must be rejected, and staggered changes on two lines that share the threshold but must switch at different ticks. Bypass is exercised both through cleared enables and through a zero threshold, where the output must follow the input combinationally. A run at the maximum threshold separates off-by-one faults in the tick count. Masked writes with partial, full and empty masks separate the mask from the value half of the write word.

// File: rtl/dbn_pkg.sv
// Shared definitions for the port debouncer.
// Assumes the threshold width is fixed by the register interface (8 bits).
package dbn_pkg;
    localparam int CNT_W = 8;
    typedef logic [CNT_W-1:0] dbn_count_t;
endpackage

// File: rtl/dbn_tick_gen.sv
// Free-running prescaler: asserts tick for one clock every CLKS_PER_MS clocks.
// Assumes CLKS_PER_MS >= 1; a value of 1 makes tick constantly high.
module dbn_tick_gen #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

    generate
        if (CLKS_PER_MS == 1) begin : g_every
            assign tick = rst_n;
        end else begin : g_div
            logic [PW-1:0] div_q;
            // Count clocks and wrap at the last count of each period.
            always_ff @(posedge clk) begin
                if (!rst_n)            div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/dbn_enable_reg.sv
// Per-line enable bits updated by masked write (upper half mask, lower half value).
// Assumes the write word is valid whenever wr is high.
module dbn_enable_reg #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [2*PINS-1:0] wdata,
    output logic [PINS-1:0] en
);
    logic [PINS-1:0] mask, val;
    assign mask = wdata[2*PINS-1:PINS];
    assign val  = wdata[PINS-1:0];

    // Replace only the masked bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)  en <= '0;
        else if (wr) en <= (en & ~mask) | (val & mask);
    end
endmodule

// File: rtl/dbn_pin_filter.sv
// One-line debounce filter: output follows raw after it disagrees for `count`
// consecutive ticks; bypass when disabled or count is zero.
// Assumes raw is synchronous to clk.
module dbn_pin_filter
    import dbn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       raw,
    input  logic       enable,
    input  dbn_count_t count,
    output logic       filt
);
    logic       hold_q;
    dbn_count_t cnt_q;
    logic       active;
    logic [CNT_W:0] next_cnt;

    assign active   = enable && (count != '0);
    assign next_cnt = {1'b0, cnt_q} + 1'b1;

    // Track raw in bypass, otherwise count ticks of disagreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!active) begin
            hold_q <= raw;
            cnt_q  <= '0;
        end else if (raw == hold_q) begin
            cnt_q  <= '0;
        end else if (tick) begin
            if (next_cnt >= {1'b0, count}) begin
                hold_q <= raw;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= next_cnt[CNT_W-1:0];
            end
        end
    end

    assign filt = active ? hold_q : raw;
endmodule

// File: rtl/dbn_port_filter.sv
// Port-level debouncer: shared tick and threshold, per-line enables and filters.
// Assumes raw_in is already synchronised to clk.
module dbn_port_filter
    import dbn_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int CLKS_PER_MS = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   raw_in,
    input  logic [CNT_W-1:0]  dbc_count,
    input  logic              en_wr,
    input  logic [2*PINS-1:0] en_wdata,
    output logic [PINS-1:0]   en_state,
    output logic [PINS-1:0]   filt_out
);
    logic ms_tick;

    dbn_tick_gen #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ms_tick)
    );

    dbn_enable_reg #(.PINS(PINS)) u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (en_wr),
        .wdata(en_wdata),
        .en   (en_state)
    );

    generate
        for (genvar i = 0; i < PINS; i++) begin : g_pin
            dbn_pin_filter u_flt (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (ms_tick),
                .raw   (raw_in[i]),
                .enable(en_state[i]),
                .count (dbc_count),
                .filt  (filt_out[i])
            );
        end
    endgenerate
endmodule

// File: rtl/dbn_port_filter_chk.sv
// Assertion checker for dbn_port_filter, attached by bind.
module dbn_port_filter_chk #(
    parameter int PINS = 8,
    parameter int CLKS_PER_MS = 50000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PINS-1:0]   raw_in,
    input logic [7:0]        dbc_count,
    input logic              en_wr,
    input logic [2*PINS-1:0] en_wdata,
    input logic [PINS-1:0]   en_state,
    input logic [PINS-1:0]   filt_out,
    input logic              ms_tick
);
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (CLKS_PER_MS > 1 && ms_tick) |=> !ms_tick); // R1

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_wr) |-> $stable(en_state)); // R3

    AST_EN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_wr) |-> (((en_state ^ $past(en_state)) & ~$past(en_wdata[2*PINS-1:PINS])) == '0)); // R3

    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_out ^ raw_in) & (~en_state)) == '0); // R4

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (dbc_count == 8'd0) |-> (filt_out == raw_in)); // R7

    AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ms_tick) && $stable(en_state) && $stable(dbc_count) && dbc_count != 8'd0)
        |-> (((filt_out ^ $past(filt_out)) & en_state) == '0)); // R5
endmodule

bind dbn_port_filter dbn_port_filter_chk #(.PINS(PINS), .CLKS_PER_MS(CLKS_PER_MS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (raw_in),
    .dbc_count(dbc_count),
    .en_wr    (en_wr),
    .en_wdata (en_wdata),
    .en_state (en_state),
    .filt_out (filt_out),
    .ms_tick  (ms_tick)
);

// File: tb/tb_dbn_port_filter.sv
module tb_dbn_port_filter;
    localparam int PINS = 8;
    localparam int NDIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PINS-1:0]   raw_in = '0;
    logic [7:0]        dbc_count = '0;
    logic              en_wr = 1'b0;
    logic [2*PINS-1:0] en_wdata = '0;
    logic [PINS-1:0]   en_state, filt_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R8";
    bit done = 0;

    // reference model state
    int m_div = 0;
    int m_cnt[PINS];
    bit m_hold[PINS];
    bit [PINS-1:0] m_en = '0;

    always #10 clk = ~clk;

    dbn_port_filter #(.PINS(PINS), .CLKS_PER_MS(NDIV)) dut (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .dbc_count(dbc_count),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_state(en_state), .filt_out(filt_out)
    );

    // Behavioural model update at each rising edge.
    always @(posedge clk) begin
        bit tk;
        if (!rst_n) begin
            m_div = 0; m_en = '0;
            foreach (m_cnt[i]) begin m_cnt[i] = 0; m_hold[i] = 0; end
        end else begin
            tk = (m_div == NDIV - 1);
            for (int i = 0; i < PINS; i++) begin
                if (!m_en[i] || dbc_count == 0) begin
                    m_hold[i] = raw_in[i]; m_cnt[i] = 0;
                end else if (raw_in[i] == m_hold[i]) begin
                    m_cnt[i] = 0;
                end else if (tk) begin
                    if (m_cnt[i] + 1 >= int'(dbc_count)) begin
                        m_hold[i] = raw_in[i]; m_cnt[i] = 0;
                    end else m_cnt[i] = m_cnt[i] + 1;
                end
            end
            m_div = tk ? 0 : m_div + 1;
            if (en_wr)
                for (int i = 0; i < PINS; i++)
                    if (en_wdata[PINS+i]) m_en[i] = en_wdata[i];
        end
    end

    function automatic bit [PINS-1:0] m_out();
        bit [PINS-1:0] r;
        for (int i = 0; i < PINS; i++)
            r[i] = (m_en[i] && dbc_count != 0) ? m_hold[i] : raw_in[i];
        return r;
    endfunction

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (filt_out !== m_out() || en_state !== m_en) begin
                errors++;
                $display("FAIL %s cycle compare: out=%h en=%h expected out=%h en=%h",
                         cur_req, filt_out, en_state, m_out(), m_en);
            end
        end
    end

    task automatic chk(string req, logic [PINS-1:0] act, logic [PINS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr_en(logic [PINS-1:0] mask, logic [PINS-1:0] val);
        en_wr = 1'b1; en_wdata = {mask, val};
        cyc(1);
        en_wr = 1'b0; en_wdata = '0;
    endtask

    initial begin
        cyc(3);
        chk("R8", filt_out, 8'h00);
        chk("R8", en_state, 8'h00);
        rst_n = 1'b1;
        cyc(1);
        chk("R8", en_state, 8'h00);

        // R4: disabled lines pass through
        cur_req = "R4";
        dbc_count = 8'd3;
        raw_in = 8'hA5; #1; chk("R4", filt_out, 8'hA5);
        raw_in = 8'h5A; #1; chk("R4", filt_out, 8'h5A);
        raw_in = 8'h00; cyc(1);

        // R3: masked enable writes
        cur_req = "R3";
        wr_en(8'h0F, 8'h05); chk("R3", en_state, 8'h05);
        wr_en(8'hF0, 8'hFF); chk("R3", en_state, 8'hF5);
        wr_en(8'h00, 8'h0A); chk("R3", en_state, 8'hF5);
        wr_en(8'hFF, 8'h03); chk("R3", en_state, 8'h03);

        // R5: steady change on line 0 switches after 3 ticks
        cur_req = "R5";
        raw_in[0] = 1'b1;
        cyc(NDIV); chk("R5", filt_out, 8'h00);
        cyc(2 * NDIV); chk("R5", filt_out, 8'h01);

        // R6: short pulse on line 1 rejected
        cur_req = "R6";
        raw_in[1] = 1'b1;
        cyc(2 * NDIV);
        raw_in[1] = 1'b0;
        cyc(4 * NDIV); chk("R6", filt_out, 8'h01);

        // R2: shared threshold, independent counters
        cur_req = "R2";
        dbc_count = 8'd2;
        raw_in[0] = 1'b0; cyc(1);
        cyc(3 * NDIV);
        raw_in = 8'h00; cyc(1);
        raw_in[0] = 1'b1;
        cyc(NDIV);
        raw_in[1] = 1'b1;
        cyc(NDIV); chk("R2", filt_out[1:0], 2'b01);
        cyc(NDIV); chk("R2", filt_out[1:0], 2'b11);

        // R7: zero threshold bypasses enabled lines
        cur_req = "R7";
        dbc_count = 8'd0;
        raw_in = 8'h02; #1; chk("R7", filt_out, 8'h02);
        raw_in = 8'h01; #1; chk("R7", filt_out, 8'h01);
        cyc(1);

        // R9: maximum threshold
        cur_req = "R9";
        raw_in = 8'h00; cyc(1);
        dbc_count = 8'd255;
        cyc(1);
        raw_in[0] = 1'b1;
        cyc(254 * NDIV); chk("R9", filt_out[0], 1'b0);
        cyc(2 * NDIV);   chk("R9", filt_out[0], 1'b1);

        // R1: model comparison above covers tick spacing; one reset-aligned check
        cur_req = "R1";
        rst_n = 1'b0; cyc(2); rst_n = 1'b1;
        chk("R8", en_state, 8'h00);
        wr_en(8'hFF, 8'h01);
        dbc_count = 8'd1;
        raw_in = 8'h01;
        cyc(NDIV + 1); chk("R1", filt_out[0], 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule